// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a switch matrix of up to sixteen rows and eight columns wired to a set of general-purpose pins. Every pin has a row field and a column field. A pin can serve as a row line, as a column line, or be left unused. The scanner works through the row indices in ascending order. For each row index it pulls low every pin assigned to that index and reads the column pins through their pull-ups. A key counts as down only when its column reads low on every sample of a programmable debounce window at the end of the row slot.

After the last row, the block publishes a snapshot. The snapshot holds up to eight packed key-entry bytes and a count of all keys found down. A one-cycle strobe marks each new snapshot. A programmable gap of idle cycles separates one pass from the next, and the scan runs only while the enable input is high. A host reads the packed entries on each strobe and does its own key mapping.

Top module: `keypad_scanner`

## Requirements
- R1: Each entry is a byte: bit 7 is valid, bits 6:3 are the row index and bits 2:0 are the column index. Entry k occupies bits [8k+7:8k] of the entry vector, so the first four entries fill the low 32-bit word with the first entry in the lowest byte.
- R2: Entries are listed in ascending row order, and in ascending column order within a row. At most eight entries are kept per pass and later keys are dropped. Unused entries read 0x00, so the valid bits always form a run that starts at entry 0.
- R3: The key count equals the number of keys accepted in the pass, including keys dropped by R2.
- R4: With debounce D and repeat gap G, consecutive snapshot strobes are 5 + 16·(16 + D) + 1 + G cycles apart. Each strobe lasts exactly one cycle.
- R5: A row slot lasts 16 + D cycles, numbered from 0. A key is accepted only if its column reads low on every cycle from 15 to 15 + D of its row's slot.
- R6: A debounce input above 1023 acts as 1023.
- R7: The row field of pin p is bits [5p+4:5p]: bit 5p enables the pin as a row and bits [5p+4:5p+1] give the row index. A pin is pulled low (pin_oe_o high) only during the slot of its row index, and only if it is enabled as a row.
- R8: The column field of pin p is bits [4p+3:4p]: bit 4p enables the pin as a column and bits [4p+3:4p+1] give the column index. A pin enabled as a row is never read as a column. A column index that no pin claims reports no keys.
- R9: While the enable input is low, no pin is pulled low, no strobe is issued and the outputs hold. Raising the enable input starts a fresh pass.
- R10: After reset, the entries, the count, the strobe and all pin enables are zero.
- R11: The entries and the count change only on the cycle the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | Scan enable |
| row_cfg_i | input | 120 | Per-pin row fields, 5 bits per pin |
| col_cfg_i | input | 96 | Per-pin column fields, 4 bits per pin |
| debounce_i | input | 12 | Debounce window extension in cycles (saturates at 1023) |
| repeat_i | input | 16 | Idle cycles between passes |
| pin_in_i | input | 24 | Sensed pin levels (pulled up) |
| pin_oe_o | output | 24 | Pull pin low when set |
| entries_o | output | 64 | Eight packed key entries |
| key_cnt_o | output | 8 | Keys found down in the last pass |
| snap_o | output | 1 | One-cycle snapshot strobe |

## Verification
A wrong row counter or pin decode appears at the pins first: pin_oe_o pulls the wrong pins low within the slot where the error occurs, and the entries published at the end of that pass carry the wrong row or column fields. A fault in the debounce window or in the slot length does not change which pins are driven. It shows up either as a missing or extra key in the next snapshot, or as a change in the spacing between strobes, which is visible after one full pass. Faults in packing or counting appear as valid bits that are not contiguous from entry 0, or as a count that disagrees with them, at the first strobe.

// File: rtl/kpscan_pkg.sv
package kpscan_pkg;
   localparam int ENT_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_ROW,
      ST_DONE,
      ST_GAP
   } scan_st_e;

   function automatic logic [ENT_W-1:0] mk_entry(input logic [3:0] r, input logic [2:0] c);
      return {1'b1, r, c};
   endfunction
endpackage

// File: rtl/kpscan_router.sv
module kpscan_router #(
   parameter int PINS = 24,
   parameter int COLS = 8
) (
   input  logic [PINS*5-1:0] row_cfg_i,
   input  logic [PINS*4-1:0] col_cfg_i,
   input  logic [3:0]        row_sel_i,
   input  logic              drive_i,
   input  logic [PINS-1:0]   pin_in_i,
   output logic [PINS-1:0]   pin_oe_o,
   output logic [COLS-1:0]   col_low_o
);
   logic [PINS-1:0] is_row;
   logic [PINS-1:0] is_col;
   logic [3:0]      ridx [PINS];
   logic [2:0]      cidx [PINS];

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign is_row[p]   = row_cfg_i[p*5];
      assign ridx[p]     = row_cfg_i[p*5+1 +: 4];
      assign is_col[p]   = col_cfg_i[p*4] & ~is_row[p];
      assign cidx[p]     = col_cfg_i[p*4+1 +: 3];
      assign pin_oe_o[p] = drive_i & is_row[p] & (ridx[p] == row_sel_i);
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [PINS-1:0] hit;
      for (genvar p = 0; p < PINS; p++) begin : g_hit
         assign hit[p] = is_col[p] & (cidx[p] == 3'(c)) & ~pin_in_i[p];
      end
      assign col_low_o[c] = |hit;
   end
endmodule

// File: rtl/kpscan_debounce.sv
module kpscan_debounce #(
   parameter int COLS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_start_i,
   input  logic            watch_i,
   input  logic [COLS-1:0] col_low_i,
   output logic [COLS-1:0] stable_o
);
   logic [COLS-1:0] ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ok_q <= '0;
      else if (slot_start_i) ok_q <= '1;
      else if (watch_i)      ok_q <= ok_q & col_low_i;
   end

   assign stable_o = ok_q & col_low_i;
endmodule

// File: rtl/kpscan_pack.sv
module kpscan_pack import kpscan_pkg::*; #(
   parameter int COLS    = 8,
   parameter int ENTRIES = 8,
   parameter int KC_W    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     push_i,
   input  logic [3:0]               row_i,
   input  logic [COLS-1:0]          down_i,
   output logic [ENTRIES*ENT_W-1:0] ent_o,
   output logic [KC_W-1:0]          total_o
);
   localparam int RK_W   = $clog2(ENTRIES + COLS + 1);
   localparam int FILL_W = $clog2(ENTRIES + 1);

   logic [FILL_W-1:0] fill_q;
   logic [RK_W-1:0]   pre [COLS+1];

   assign pre[0] = RK_W'(fill_q);
   for (genvar c = 0; c < COLS; c++) begin : g_rank
      assign pre[c+1] = pre[c] + RK_W'(down_i[c]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_o   <= '0;
         fill_q  <= '0;
         total_o <= '0;
      end else if (clear_i) begin
         ent_o   <= '0;
         fill_q  <= '0;
         total_o <= '0;
      end else if (push_i) begin
         for (int c = 0; c < COLS; c++) begin
            if (down_i[c] && (pre[c] < RK_W'(ENTRIES)))
               ent_o[pre[c]*ENT_W +: ENT_W] <= mk_entry(row_i, 3'(c));
         end
         fill_q  <= (pre[COLS] >= RK_W'(ENTRIES)) ? FILL_W'(ENTRIES) : FILL_W'(pre[COLS]);
         total_o <= total_o + KC_W'(pre[COLS] - RK_W'(fill_q));
      end
   end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner import kpscan_pkg::*; #(
   parameter int PINS     = 24,
   parameter int ROWS     = 16,
   parameter int COLS     = 8,
   parameter int ENTRIES  = 8,
   parameter int ROW_CYC  = 16,
   parameter int LEAD_CYC = 5,
   parameter int DB_IN_W  = 12,
   parameter int DB_W     = 10,
   parameter int RPT_W    = 16,
   parameter int KC_W     = $clog2(ROWS*COLS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scan_en_i,
   input  logic [PINS*5-1:0]        row_cfg_i,
   input  logic [PINS*4-1:0]        col_cfg_i,
   input  logic [DB_IN_W-1:0]       debounce_i,
   input  logic [RPT_W-1:0]         repeat_i,
   input  logic [PINS-1:0]          pin_in_i,
   output logic [PINS-1:0]          pin_oe_o,
   output logic [ENTRIES*ENT_W-1:0] entries_o,
   output logic [KC_W-1:0]          key_cnt_o,
   output logic                     snap_o
);
   localparam int DB_MAX = (1 << DB_W) - 1;
   localparam int SLOT_W = $clog2(ROW_CYC + DB_MAX + 1);
   localparam int CNT_W  = (SLOT_W > RPT_W) ? SLOT_W : RPT_W;

   if (ROWS < 1 || ROWS > 16) begin : g_bad_rows
      $error("ROWS must be 1..16");
   end
   if (COLS < 1 || COLS > 8) begin : g_bad_cols
      $error("COLS must be 1..8");
   end
   if (ENTRIES < 1) begin : g_bad_ent
      $error("ENTRIES must be at least 1");
   end
   if (ROW_CYC < 2 || LEAD_CYC < 1) begin : g_bad_time
      $error("ROW_CYC must be >= 2 and LEAD_CYC >= 1");
   end
   if (DB_IN_W < DB_W) begin : g_bad_db
      $error("DB_IN_W must be at least DB_W");
   end
   if (KC_W < $clog2(ROWS*COLS + 1)) begin : g_bad_kc
      $error("KC_W too narrow for the matrix");
   end

   scan_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       row_q;
   logic [DB_W-1:0]  db_eff;
   logic [CNT_W-1:0] slot_last;
   logic [CNT_W-1:0] rpt_last;
   logic             in_row, slot_start, watch, row_end, pack_clear;
   logic [COLS-1:0]  col_low, down;
   logic [ENTRIES*ENT_W-1:0] stage_ent;
   logic [KC_W-1:0]  stage_cnt;

   always_comb begin
      if (debounce_i > DB_IN_W'(DB_MAX)) db_eff = DB_W'(DB_MAX);
      else                               db_eff = debounce_i[DB_W-1:0];
   end

   assign slot_last  = CNT_W'(ROW_CYC - 1) + CNT_W'(db_eff);
   assign rpt_last   = CNT_W'(repeat_i) - CNT_W'(1);
   assign in_row     = (st_q == ST_ROW);
   assign slot_start = in_row && (cnt_q == '0);
   assign watch      = in_row && (cnt_q >= CNT_W'(ROW_CYC - 1));
   assign row_end    = in_row && (cnt_q == slot_last);
   assign pack_clear = (st_q == ST_LEAD) && (cnt_q == '0);

   kpscan_router #(.PINS(PINS), .COLS(COLS)) u_router (
      .row_cfg_i (row_cfg_i),
      .col_cfg_i (col_cfg_i),
      .row_sel_i (row_q),
      .drive_i   (in_row),
      .pin_in_i  (pin_in_i),
      .pin_oe_o  (pin_oe_o),
      .col_low_o (col_low)
   );

   kpscan_debounce #(.COLS(COLS)) u_deb (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_start_i (slot_start),
      .watch_i      (watch),
      .col_low_i    (col_low),
      .stable_o     (down)
   );

   kpscan_pack #(.COLS(COLS), .ENTRIES(ENTRIES), .KC_W(KC_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (pack_clear),
      .push_i  (row_end),
      .row_i   (row_q),
      .down_i  (down),
      .ent_o   (stage_ent),
      .total_o (stage_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cnt_q     <= '0;
         row_q     <= '0;
         snap_o    <= 1'b0;
         entries_o <= '0;
         key_cnt_o <= '0;
      end else if (!scan_en_i) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         row_q  <= '0;
         snap_o <= 1'b0;
      end else begin
         snap_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               st_q  <= ST_LEAD;
               cnt_q <= '0;
            end
            ST_LEAD: begin
               if (cnt_q == CNT_W'(LEAD_CYC - 1)) begin
                  st_q  <= ST_ROW;
                  cnt_q <= '0;
                  row_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ROW: begin
               if (row_end) begin
                  cnt_q <= '0;
                  if (row_q == 4'(ROWS - 1)) st_q <= ST_DONE;
                  else                       row_q <= row_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_DONE: begin
               entries_o <= stage_ent;
               key_cnt_o <= stage_cnt;
               snap_o    <= 1'b1;
               cnt_q     <= '0;
               st_q      <= (repeat_i == '0) ? ST_LEAD : ST_GAP;
            end
            ST_GAP: begin
               if (cnt_q == rpt_last) begin
                  st_q  <= ST_LEAD;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/kpscan_chk.sv
module kpscan_chk #(
   parameter int PINS    = 24,
   parameter int ENTRIES = 8,
   parameter int KC_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scan_en_i,
   input logic [PINS*5-1:0]    row_cfg_i,
   input logic [PINS-1:0]      pin_oe_o,
   input logic [ENTRIES*8-1:0] entries_o,
   input logic [KC_W-1:0]      key_cnt_o,
   input logic                 snap_o
);
   logic [PINS-1:0]    row_en;
   logic [ENTRIES-1:0] vld;
   logic [ENTRIES-1:0] vld_inc;

   for (genvar p = 0; p < PINS; p++) begin : g_ren
      assign row_en[p] = row_cfg_i[p*5];
   end
   for (genvar k = 0; k < ENTRIES; k++) begin : g_vld
      assign vld[k] = entries_o[k*8+7];
   end
   assign vld_inc = vld + 1'b1;

   // R7
   oe_rowpin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe_o & ~row_en) == '0);

   // R9
   oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en_i |=> (pin_oe_o == '0));

   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en_i |=> !snap_o);

   // R4
   snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_o |=> !snap_o);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_o |-> ($stable(entries_o) && $stable(key_cnt_o)));

   // R2
   packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld & vld_inc) == '0);

   // R3
   count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_o |-> ((key_cnt_o >= KC_W'(ENTRIES)) ? (vld == '1)
                                                : ($countones(vld) == int'(key_cnt_o))));
endmodule

bind keypad_scanner kpscan_chk #(.PINS(PINS), .ENTRIES(ENTRIES), .KC_W(KC_W)) u_chk (.*);

// File: tb/keypad_scanner_bench.sv
`timescale 1ns/1ps
module keypad_scanner_bench;
   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0;
   logic [119:0]  row_cfg = '0;
   logic [95:0]   col_cfg = '0;
   logic [11:0]   debounce = '0;
   logic [15:0]   rpt = '0;
   logic [23:0]   pin_in;
   logic [23:0]   pin_oe;
   logic [63:0]   entries;
   logic [7:0]    key_cnt;
   logic          snap;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int age = 0;
   logic [23:0] prev_oe = '0;
   int kr[12], kc[12], ks[12];
   int nk = 0;

   always #2.5 clk = ~clk;

   keypad_scanner u_keypad_scanner (
      .clk(clk), .rst_n(rst_n), .scan_en_i(scan_en), .row_cfg_i(row_cfg),
      .col_cfg_i(col_cfg), .debounce_i(debounce), .repeat_i(rpt),
      .pin_in_i(pin_in), .pin_oe_o(pin_oe), .entries_o(entries),
      .key_cnt_o(key_cnt), .snap_o(snap));

   // physical key model: key k shorts row pin kr[k] to column pin kc[k]
   // once the row has been pulled low for ks[k] cycles
   always @(negedge clk) begin
      if (pin_oe != prev_oe) age <= 0;
      else if (age < 1000000) age <= age + 1;
      prev_oe <= pin_oe;
   end

   always_comb begin
      pin_in = '1;
      for (int k = 0; k < 12; k++)
         if (k < nk && pin_oe[kr[k]] && age >= ks[k]) pin_in[kc[k]] = 1'b0;
   end

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ent(input int r, input int c);
      return {1'b1, 4'(r), 3'(c)};
   endfunction

   task automatic add_key(input int pr, input int pc, input int settle);
      kr[nk] = pr; kc[nk] = pc; ks[nk] = settle; nk = nk + 1;
   endtask

   task automatic default_map();
      row_cfg = '0; col_cfg = '0;
      for (int r = 0; r < 16; r++) row_cfg[5*r +: 5] = {4'(r), 1'b1};
      for (int c = 0; c < 8; c++)  col_cfg[4*(16+c) +: 4] = {3'(c), 1'b1};
   endtask

   task automatic wait_snap(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n = n + 1;
      end while (!snap && n < 40000);
   endtask

   task automatic restart();
      int n;
      @(negedge clk); scan_en = 1'b0;
      @(negedge clk); scan_en = 1'b1;
      wait_snap(n);
   endtask

   task automatic t_reset();
      check("R10 entries", entries, 64'h0);
      check("R10 count", 64'(key_cnt), 64'h0);
      check("R10 strobe", 64'(snap), 64'h0);
      check("R10 pin enables", 64'(pin_oe), 64'h0);
   endtask

   task automatic t_single();
      default_map(); nk = 0; debounce = 0; rpt = 0;
      add_key(2, 22, 0);
      restart();
      check("R1 single entry", entries, 64'(ent(2, 6)));
      check("R3 single count", 64'(key_cnt), 64'd1);
   endtask

   task automatic t_timing();
      int n;
      wait_snap(n);
      check("R4 period G=0", 64'(n), 64'd262);
      @(negedge clk);
      check("R4 strobe one cycle", 64'(snap), 64'h0);
      rpt = 16'd7;
      wait_snap(n);
      wait_snap(n);
      check("R4 period G=7", 64'(n), 64'd269);
      rpt = 0;
   endtask

   task automatic t_overflow();
      logic [63:0] exp;
      default_map(); nk = 0;
      add_key(15, 23, 0); add_key(3, 19, 0); add_key(0, 21, 0); add_key(12, 22, 0);
      add_key(1, 16, 0);  add_key(9, 17, 0); add_key(0, 17, 0); add_key(5, 18, 0);
      add_key(3, 23, 0);  add_key(8, 20, 0);
      restart();
      exp = {ent(9,1), ent(8,4), ent(5,2), ent(3,7), ent(3,3), ent(1,0), ent(0,5), ent(0,1)};
      check("R2 order and limit", entries, exp);
      check("R3 count with drops", 64'(key_cnt), 64'd10);
   endtask

   task automatic t_remap();
      row_cfg = '0; col_cfg = '0;
      for (int r = 0; r < 16; r++) row_cfg[5*r +: 5] = {4'(15 - r), 1'b1};
      for (int c = 0; c < 8; c++)  col_cfg[4*(16+c) +: 4] = {3'(7 - c), 1'b1};
      nk = 0;
      add_key(2, 17, 0); add_key(15, 23, 0);
      restart();
      check("R7 R8 remapped fields", entries, {48'h0, ent(13, 6), ent(0, 0)});
      check("R3 remapped count", 64'(key_cnt), 64'd2);
   endtask

   task automatic t_ignore();
      default_map();
      row_cfg[20] = 1'b0;                       // pin 4 no longer a row
      col_cfg[76] = 1'b0;                       // pin 19 no longer a column
      row_cfg[5*20 +: 5] = {4'd15, 1'b1};       // pin 20 both row and column
      nk = 0;
      add_key(4, 16, 0); add_key(1, 19, 0); add_key(1, 16, 0); add_key(3, 20, 0);
      restart();
      check("R7 R8 ignored pins", entries, 64'(ent(1, 0)));
      check("R8 ignored count", 64'(key_cnt), 64'd1);
   endtask

   task automatic t_debounce();
      int n;
      default_map(); nk = 0; debounce = 12'd4;
      add_key(0, 16, 15); add_key(1, 17, 16);
      restart();
      check("R5 window accept and reject", entries, 64'(ent(0, 0)));
      check("R5 count", 64'(key_cnt), 64'd1);
      wait_snap(n);
      check("R5 slot length D=4", 64'(n), 64'd326);
   endtask

   task automatic t_saturate();
      int n;
      default_map(); nk = 0; debounce = 12'hFFF;
      add_key(7, 23, 0);
      restart();
      check("R6 content", entries, 64'(ent(7, 7)));
      wait_snap(n);
      check("R6 saturated period", 64'(n), 64'd16630);
      debounce = 0;
   endtask

   task automatic t_disable();
      logic [63:0] held;
      int bad_oe, bad_snap, bad_hold, n;
      default_map(); nk = 0; debounce = 0; rpt = 0;
      add_key(6, 18, 0);
      restart();
      held = entries;
      repeat (40) @(negedge clk);
      scan_en = 1'b0;
      nk = 0; add_key(11, 21, 0);
      bad_oe = 0; bad_snap = 0; bad_hold = 0;
      @(negedge clk);
      repeat (300) begin
         @(negedge clk);
         if (pin_oe != '0) bad_oe++;
         if (snap) bad_snap++;
         if (entries != held) bad_hold++;
      end
      check("R9 pins released", 64'(bad_oe), 64'd0);
      check("R9 no strobe", 64'(bad_snap), 64'd0);
      check("R11 outputs hold", 64'(bad_hold), 64'd0);
      scan_en = 1'b1;
      wait_snap(n);
      check("R9 fresh pass latency", 64'(n), 64'd263);
      check("R9 fresh pass content", entries, 64'(ent(11, 5)));
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_timing();
      t_overflow();
      t_remap();
      t_ignore();
      t_debounce();
      t_saturate();
      t_disable();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule